// File: doc/BRIEF.md
# Self-Repairing Machine-Cycle Phase Ring

This block generates the eight phase strobes that divide each machine cycle of a small 4-bit processor, together with a cycle marker for the memory and I/O chips around it. The phases run in a fixed order: three address phases (A1, A2, A3), two memory phases (M1, M2) and three execute phases (X1, X2, X3). Each phase is one flop of an eight-stage circulating shift register, and exactly one of these flops is high in normal operation. The register moves on by one stage for each full period of the two-phase system clock. It steps on the rising edge of a clock-enable level that stands for the second clock phase.

The ring needs no load sequence to start. The first stage refills with a one only when every stage from A1 through X2 is empty. Every other stage copies its lower neighbour, and the X3 stage shifts out of the top. A cleared register therefore produces A1 on its first step. Any pattern with several ones drains until one token is left, so the ring becomes legal again on its own after an upset. The marker output is high during X3, which tells external chips that a new machine cycle begins on the next step. A preset path can write any pattern into the ring. This models a corrupted state and shows how the ring repairs itself.

Top module: `phase_ring_gen`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all eight phase outputs and the sync output go low, and they stay low until the first step after reset is released.
- R2: The ring steps only on a clock edge where `phi2_en` is sampled high after being sampled low on the previous edge. Holding `phi2_en` high for further edges, or holding it low, leaves the phase outputs unchanged. The new pattern is visible right after the stepping edge.
- R3: Bit positions are A1=0, A2=1, A3=2, M1=3, M2=4, X1=5, X2=6, X3=7. From a legal one-hot state each step moves the token to the next higher bit, and X3 (bit 7) wraps to A1 (bit 0).
- R4: On a step, bit 0 becomes 1 exactly when bits 0 through 6 were all 0, and it becomes 0 otherwise. Each bit i from 1 to 7 takes the old value of bit i-1.
- R5: From the all-zero state, the first step produces only A1 (value 8'h01).
- R6: From any of the 256 possible patterns, the ring is one-hot after at most 8 steps and stays one-hot on every later step.
- R7: `sync` is high exactly when the X3 phase (bit 7) is high, in every cycle after reset, including after a preset.
- R8: When `force_en` is sampled high, `force_val` is written into the ring at that edge. This takes priority over a step in the same cycle. Reset takes priority over the preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phi2_en | input | 1 | Second clock phase enable level; its rising edge steps the ring |
| force_en | input | 1 | Preset strobe that writes an arbitrary ring pattern |
| force_val | input | 8 | Pattern written when `force_en` is high |
| phase | output | 8 | One-hot phase strobes, bit 0 = A1 up to bit 7 = X3 |
| sync | output | 1 | Cycle marker, high during X3 |

## Verification
Every result of this block is due on the clock edge that samples its cause. A step, a preset or a reset all change `phase` and `sync` right after that single edge, and there is no extra pipeline stage. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. Each step is followed by one edge with `phi2_en` low, so that an unwanted second step would show up as a changed output. All 256 preset patterns are swept. For each one the arithmetic next-state rule is applied for nine steps, and the bench compares every intermediate pattern, the marker, and the one-hot property by step eight.

// File: rtl/phase_pkg.sv
package phase_pkg;

    // Number of machine-cycle phases in the ring
    localparam int NUM_PH = 8;
    localparam int PH_IDX_W = $clog2(NUM_PH);

    // Phase positions; the bit order is the stepping order
    typedef enum logic [PH_IDX_W-1:0] {
        PH_A1 = 3'd0,
        PH_A2 = 3'd1,
        PH_A3 = 3'd2,
        PH_M1 = 3'd3,
        PH_M2 = 3'd4,
        PH_X1 = 3'd5,
        PH_X2 = 3'd6,
        PH_X3 = 3'd7
    } phase_e;

    typedef logic [NUM_PH-1:0] ring_t;

    // Control bundle passed from the top to the storage elements
    typedef struct packed {
        logic  step;
        logic  load;
        ring_t load_val;
    } ring_ctl_t;

    // True when exactly one bit is set
    function automatic logic ring_is_onehot(input ring_t r);
        logic seen;
        logic bad;
        seen = 1'b0;
        bad  = 1'b0;
        for (int i = 0; i < NUM_PH; i++) begin
            if (r[i]) begin
                bad  = bad | seen;
                seen = 1'b1;
            end
        end
        return seen & ~bad;
    endfunction

endpackage

// File: rtl/phase_edge_det.sv
module phase_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic pulse_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign pulse_o = lvl_i & ~prev_q;

    // A step pulse can never last two consecutive cycles
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R2

endmodule

// File: rtl/phase_sync.sv
module phase_sync #(
    parameter int N = phase_pkg::NUM_PH
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic load_i,
    input  logic load_top_i,
    input  logic below_top_i,
    output logic sync_o
);

    logic sync_q;

    // Own flop for the marker: it predicts the top ring bit rather than tapping it
    always_ff @(posedge clk) begin
        if (rst)         sync_q <= 1'b0;
        else if (load_i) sync_q <= load_top_i;
        else if (step_i) sync_q <= below_top_i;
    end

    assign sync_o = sync_q;

    // The marker only moves on a step or a preset
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(sync_o)); // R7

endmodule

// File: rtl/phase_ring.sv
module phase_ring
    import phase_pkg::*;
#(
    parameter int N = NUM_PH
) (
    input  logic         clk,
    input  logic         rst,
    input  ring_ctl_t    ctl_i,
    output logic [N-1:0] ring_o
);

    localparam int CNT_W = $clog2(N + 1);

    logic [N-1:0] q;
    logic         low_empty;

    // Stages A1..X2 all empty: the refill condition for the first stage
    assign low_empty = ~|q[N-2:0];

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)             q[i] <= 1'b0;
                else if (ctl_i.load) q[i] <= ctl_i.load_val[i];
                else if (ctl_i.step) q[i] <= low_empty;
            end
        end else if (i == N - 1) begin : g_last
            // Top stage: its old value leaves the ring on a step
            always_ff @(posedge clk) begin
                if (rst)             q[i] <= 1'b0;
                else if (ctl_i.load) q[i] <= ctl_i.load_val[i];
                else if (ctl_i.step) q[i] <= q[i-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)             q[i] <= 1'b0;
                else if (ctl_i.load) q[i] <= ctl_i.load_val[i];
                else if (ctl_i.step) q[i] <= q[i-1];
            end
        end
    end

    assign ring_o = q;

    // Counter of steps taken while the ring was not one-hot
    logic [CNT_W-1:0] bad_steps;
    logic             legal;

    assign legal = ring_is_onehot(q);

    always_ff @(posedge clk) begin
        if (rst || ctl_i.load)       bad_steps <= '0;
        else if (legal)              bad_steps <= '0;
        else if (ctl_i.step)         bad_steps <= bad_steps + 1'b1;
    end

    AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (rst)
        !legal |-> (bad_steps < CNT_W'(N))); // R6

    AST_STAY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (legal && !ctl_i.load) |=> ring_is_onehot(ring_o)); // R6

    AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (legal && ctl_i.step && !ctl_i.load) |=>
        (ring_o == {$past(ring_o[N-2:0]), $past(ring_o[N-1])})); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.step && !ctl_i.load) |=> $stable(ring_o)); // R2

    AST_PRESET: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> (ring_o == $past(ctl_i.load_val))); // R8

endmodule

// File: rtl/phase_ring_gen.sv
module phase_ring_gen
    import phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2_en,
    input  logic              force_en,
    input  logic [NUM_PH-1:0] force_val,
    output logic [NUM_PH-1:0] phase,
    output logic              sync
);

    logic      step;
    ring_ctl_t ctl;
    ring_t     ring;

    phase_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   (phi2_en),
        .pulse_o (step)
    );

    always_comb begin
        ctl.step     = step;
        ctl.load     = force_en;
        ctl.load_val = force_val;
    end

    phase_ring #(.N(NUM_PH)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .ring_o (ring)
    );

    phase_sync #(.N(NUM_PH)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step),
        .load_i      (force_en),
        .load_top_i  (force_val[PH_X3]),
        .below_top_i (ring[PH_X2]),
        .sync_o      (sync)
    );

    assign phase = ring;

    // Marker flop and ring top stage are driven separately and must agree
    AST_SYNC_MATCH: assert property (@(posedge clk) disable iff (rst)
        sync == phase[PH_X3]); // R7

    AST_ZERO_REFILL: assert property (@(posedge clk) disable iff (rst)
        (phase == '0 && step && !force_en) |=> (phase == ring_t'(1))); // R5

endmodule

// File: tb/phase_ring_gen_bench.sv
`timescale 1ns/1ps
module phase_ring_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phi2_en = 1'b0;
    logic       force_en = 1'b0;
    logic [7:0] force_val = 8'h00;
    logic [7:0] phase;
    logic       sync;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    phase_ring_gen u_phase_ring_gen (
        .clk       (clk),
        .rst       (rst),
        .phi2_en   (phi2_en),
        .force_en  (force_en),
        .force_val (force_val),
        .phase     (phase),
        .sync      (sync)
    );

    // Next-state rule of R4
    function automatic logic [7:0] rule_next(input logic [7:0] v);
        return {v[6:0], (v[6:0] == 7'd0)};
    endfunction

    function automatic bit one_hot(input logic [7:0] v);
        return (v != 8'd0) && ((v & (v - 8'd1)) == 8'd0);
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then sample at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Step once, then a quiet edge that must not step again
    task automatic do_step();
        phi2_en = 1'b1;
        cyc();
        phi2_en = 1'b0;
        cyc();
    endtask

    task automatic preset(input logic [7:0] v);
        force_en = 1'b1;
        force_val = v;
        cyc();
        force_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        cyc();
        cyc();
        chk("R1 reset phase", {1'b0, phase}, 9'h000);
        chk("R1 reset sync", {8'h00, sync}, 9'h000);
        rst = 1'b0;
        cyc();
        chk("R1 hold after reset", {sync, phase}, 9'h000);

        // R5: first step from zero
        do_step();
        chk("R5 first step A1", {sync, phase}, 9'h001);

        // R2: hold high for several edges -> only one step
        phi2_en = 1'b1;
        cyc();
        chk("R2 step on rising edge", {sync, phase}, 9'h002);
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R2 high level no step", {sync, phase}, 9'h002);
        end
        phi2_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R2 low level no step", {sync, phase}, 9'h002);
        end

        // R3/R7: two full laps of legal rotation
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e;
            e = 8'h01 << ((k + 2) % 8);
            do_step();
            chk("R3 rotation order", {1'b0, phase}, {1'b0, e});
            chk("R7 sync on X3", {8'h00, sync}, {8'h00, e[7]});
        end

        // R4/R6/R7: exhaustive sweep of all patterns
        for (int p = 0; p < 256; p++) begin
            logic [7:0] m;
            m = 8'(p);
            preset(m);
            cyc();
            chk("R8 preset value", {sync, phase}, {m[7], m});
            for (int s = 1; s <= 9; s++) begin
                m = rule_next(m);
                do_step();
                chk("R4 next-state rule", {1'b0, phase}, {1'b0, m});
                chk("R7 sync tracks X3", {8'h00, sync}, {8'h00, phase[7]});
                if (s >= 8)
                    chk("R6 one-hot by step 8", {8'h00, one_hot(phase)}, 9'h001);
            end
        end

        // R8: preset wins over a simultaneous step
        preset(8'h01);
        phi2_en = 1'b0;
        cyc();
        phi2_en = 1'b1;
        force_en = 1'b1;
        force_val = 8'h24;
        cyc();
        force_en = 1'b0;
        phi2_en = 1'b0;
        chk("R8 preset over step", {sync, phase}, 9'h024);

        // R8: reset wins over preset
        rst = 1'b1;
        force_en = 1'b1;
        force_val = 8'h80;
        cyc();
        force_en = 1'b0;
        chk("R8 reset over preset", {sync, phase}, 9'h000);
        rst = 1'b0;
        cyc();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule